// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire Ethernet management bus towards a PHY. A caller presents one command (a read or write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data) and pulses `start`. The block then divides the system clock down to produce MDC. It shifts the complete management frame out on MDIO: a long run of ones, the start and opcode bits, the two addresses, a turnaround pair and the data field. It also steers a separate output-enable so that an external pad buffer can release the line while the PHY answers.

On a read the block checks that the PHY pulls the second turnaround bit low. If the PHY does, the 16 data bits are shifted in with the most significant bit first. If the line stays high, no PHY answered. The block then keeps the line released for a run of recovery clocks and reports the failure with a flag and an all-ones result. A one-cycle `done` pulse closes every frame. `busy` covers the whole transaction, and start pulses that arrive during a frame are dropped.

Top module: `mdio_master`

## Requirements
- R1: MDC is low whenever no frame is running. During a frame each MDC low half and each MDC high half lasts exactly HALF_DIV system clocks.
- R2: A frame begins with PRE_BITS (default 33) MDC cycles in which MDIO is driven to 1 with output-enable high.
- R3: The next four bits are the start pair 0,1 and then the opcode. The opcode is 1,0 for a read (`rd_wr`=1) and 0,1 for a write (`rd_wr`=0).
- R4: The PHY address bits follow and then the register address bits, each field most significant bit first, with output-enable high.
- R5: MDIO output changes only while MDC is low, so every bit is stable at the MDC rising edge.
- R6: A write drives the turnaround 1,0 and then 16 data bits MSB first. It then releases MDIO (output-enable low, output 0) for one more MDC cycle, for 66 MDC cycles in total.
- R7: A read releases MDIO from the first turnaround bit onward. It samples `mdio_i` in the last system clock of each MDC high half. When the second turnaround bit reads 0, it shifts in 16 bits MSB first and adds two released cycles (67 MDC cycles). `rdata` then carries the word and `nophy` is 0.
- R8: When the second read turnaround bit reads 1, the block issues RECOV_BITS (default 32) further released MDC cycles and shifts in no data (81 MDC cycles in total). It then sets `nophy` to 1 and `rdata` to 16'hFFFF.
- R9: `done` is high for exactly one cycle per frame. `busy` is high from the cycle after the accepted start through the `done` cycle and low in the cycle after.
- R10: A `start` pulse while `busy` is high is ignored: the frame on the bus is unchanged and only one `done` follows.
- R11: `rdata` and `nophy` change only in the `done` cycle. A write leaves `rdata` unchanged and clears `nophy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame with the command fields below |
| rd_wr | input | 1 | 1 for a read, 0 for a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data for a write |
| mdio_i | input | 1 | Sampled MDIO line from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output-enable for the pad buffer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last completed read |
| nophy | output | 1 | Last frame found no PHY answering |

## Verification
The hardest situation to reach is the missing-PHY path. It depends on the value of one sampled bit deep in the frame, and it lengthens the frame and rewrites the result registers. The bench models the PHY at the pins. It counts MDC rising edges and answers only in the turnaround and data slots. For an absent PHY it leaves the line pulled high, so the recovery run, the all-ones result and the later clearing of the flag by a write are all driven from the ports. A second start pulse is injected in the middle of a frame, with the opposite opcode, to show that the captured bit stream still matches the first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HDR_W  = 4 + 2 * ADDR_W;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,
    PH_HDR,
    PH_TAW,
    PH_WDAT,
    PH_TAR,
    PH_RDAT,
    PH_RECOV,
    PH_TAIL,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } cmd_t;

  // start pair, opcode, phy address, register address: sent MSB first
  function automatic logic [HDR_W-1:0] hdr_word(input logic rd,
                                                input logic [ADDR_W-1:0] phy,
                                                input logic [ADDR_W-1:0] regad);
    logic [1:0] op;
    op = rd ? 2'b10 : 2'b01;
    return {2'b01, op, phy, regad};
  endfunction

  // number of MDC cycles spent in one phase
  function automatic int unsigned seg_slots(input phase_e ph, input logic rd,
                                            input int unsigned pre_bits,
                                            input int unsigned recov_bits);
    case (ph)
      PH_PRE:           return pre_bits;
      PH_HDR:           return HDR_W;
      PH_TAW, PH_TAR:   return 2;
      PH_WDAT, PH_RDAT: return DATA_W;
      PH_RECOV:         return recov_bits;
      PH_TAIL:          return rd ? 2 : 1;
      default:          return 1;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b);
    return {v[DATA_W-2:0], b};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic fall_tick
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic          half_end;

  assign half_end  = run && (cnt_q == CW'(HALF_DIV - 1));
  assign fall_tick = half_end && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: the clock rests low outside a frame
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);

  // R1: a falling tick is followed by MDC low
  p_fall_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_BITS   = 33,
  parameter int unsigned RECOV_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic              mdio_i,
  input  logic              fall_tick,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              nophy,
  output logic              ta_sample,
  output logic              frame_end
);
  localparam int unsigned MAXSEG = max3(PRE_BITS, RECOV_BITS, HDR_W);
  localparam int unsigned CNT_W  = $clog2(MAXSEG + 1);

  phase_e            ph_q, ph_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  seg_last;
  cmd_t              cmd_q;
  logic [HDR_W-1:0]  hdr_sr;
  logic [DATA_W-1:0] wsr;
  logic [DATA_W-1:0] rsr;
  logic [DATA_W-1:0] rdata_q;
  logic              nophy_q;
  logic              slot_end;

  assign seg_last  = CNT_W'(seg_slots(ph_q, cmd_q.rd, PRE_BITS, RECOV_BITS) - 1);
  assign run       = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
  assign busy      = (ph_q != PH_IDLE);
  assign done      = (ph_q == PH_DONE);
  assign slot_end  = run && fall_tick && (cnt_q == seg_last);
  assign ta_sample = slot_end && (ph_q == PH_TAR);
  assign frame_end = slot_end && ((ph_q == PH_RECOV) || (ph_q == PH_TAIL));
  assign rdata     = rdata_q;
  assign nophy     = nophy_q;

  always_comb begin
    case (ph_q)
      PH_PRE:   ph_nx = PH_HDR;
      PH_HDR:   ph_nx = cmd_q.rd ? PH_TAR : PH_TAW;
      PH_TAW:   ph_nx = PH_WDAT;
      PH_WDAT:  ph_nx = PH_TAIL;
      PH_TAR:   ph_nx = mdio_i ? PH_RECOV : PH_RDAT;
      PH_RDAT:  ph_nx = PH_TAIL;
      PH_RECOV: ph_nx = PH_DONE;
      PH_TAIL:  ph_nx = PH_DONE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b0;
    case (ph_q)
      PH_PRE: begin
        mdio_oe = 1'b1;
        mdio_o  = 1'b1;
      end
      PH_HDR: begin
        mdio_oe = 1'b1;
        mdio_o  = hdr_sr[HDR_W-1];
      end
      PH_TAW: begin
        mdio_oe = 1'b1;
        mdio_o  = (cnt_q == '0);
      end
      PH_WDAT: begin
        mdio_oe = 1'b1;
        mdio_o  = wsr[DATA_W-1];
      end
      default: begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      hdr_sr  <= '0;
      wsr     <= '0;
      rsr     <= '0;
      rdata_q <= '0;
      nophy_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            cmd_q  <= cmd;
            hdr_sr <= hdr_word(cmd.rd, cmd.phy, cmd.regad);
            wsr    <= cmd.wdata;
            cnt_q  <= '0;
            ph_q   <= PH_PRE;
          end
        end
        PH_DONE: ph_q <= PH_IDLE;
        default: begin
          if (fall_tick) begin
            case (ph_q)
              PH_HDR:  hdr_sr <= {hdr_sr[HDR_W-2:0], 1'b0};
              PH_WDAT: wsr    <= {wsr[DATA_W-2:0], 1'b0};
              PH_RDAT: rsr    <= shift_in(rsr, mdio_i);
              default: ;
            endcase
            if (slot_end) begin
              cnt_q <= '0;
              ph_q  <= ph_nx;
              if (ph_q == PH_RECOV) begin
                rdata_q <= '1;
                nophy_q <= 1'b1;
              end else if (ph_q == PH_TAIL) begin
                nophy_q <= 1'b0;
                if (cmd_q.rd) rdata_q <= rsr;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R7: the line is released while the turnaround bit is sampled
  p_ta_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ta_sample |-> !mdio_oe);

  // R8: a missing PHY reports all ones
  p_nophy_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nophy) |-> (rdata == '1));

  // R9: busy holds until the completion pulse
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R9: done lasts one cycle and busy drops after it
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R11: results move only on completion
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  p_nophy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nophy) |-> done);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV   = 40,
  parameter int unsigned PRE_BITS   = 33,
  parameter int unsigned RECOV_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              nophy
);
  cmd_t cmd_in;
  logic run;
  logic fall_tick;
  logic ta_sample;
  logic frame_end;

  assign cmd_in.rd    = rd_wr;
  assign cmd_in.phy   = phy_addr;
  assign cmd_in.regad = reg_addr;
  assign cmd_in.wdata = wdata;

  mdio_mdc_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mdc      (mdc),
    .fall_tick(fall_tick)
  );

  mdio_frame_seq #(
    .PRE_BITS  (PRE_BITS),
    .RECOV_BITS(RECOV_BITS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd_in),
    .mdio_i   (mdio_i),
    .fall_tick(fall_tick),
    .run      (run),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .nophy    (nophy),
    .ta_sample(ta_sample),
    .frame_end(frame_end)
  );

  // R5: data moves only while the clock is low
  p_data_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

  // R7: turnaround is sampled in the high half of MDC
  p_ta_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ta_sample |-> mdc);

  // R9: the last slot leads straight to the completion pulse
  p_end_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done);

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_wr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, busy, done, nophy;
  logic [15:0] rdata;

  int tests = 0;
  int fails = 0;

  int  nrise = 0;
  bit  obs_o [0:127];
  bit  obs_oe[0:127];
  bit  phy_present = 1'b1;
  bit  rd_frame = 1'b0;
  logic [15:0] phy_data = '0;
  int  done_cnt = 0;
  int  half_bad = 0;
  int  r5_bad = 0;
  int  seg = 0;
  bit  have_tog = 1'b0;
  logic prev_mdc = 1'b0;
  logic prev_o = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .done(done), .rdata(rdata), .nophy(nophy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected {oe, o} seen at the rising edge of MDC number s
  function automatic logic [1:0] exp_slot(input int s, input bit rd,
                                          input logic [4:0] pa, input logic [4:0] ra,
                                          input logic [15:0] wd);
    if (s < 33) return 2'b11;
    if (s == 33) return 2'b10;
    if (s == 34) return 2'b11;
    if (s == 35) return {1'b1, rd};
    if (s == 36) return {1'b1, ~rd};
    if (s < 42) return {1'b1, pa[41-s]};
    if (s < 47) return {1'b1, ra[46-s]};
    if (rd) return 2'b00;
    if (s == 47) return 2'b11;
    if (s == 48) return 2'b10;
    if (s < 65) return {1'b1, wd[64-s]};
    return 2'b00;
  endfunction

  function automatic string slot_req(input int s, input bit rd, input bit present);
    if (s < 33) return "R2";
    if (s < 37) return "R3";
    if (s < 47) return "R4";
    if (!rd) return "R6";
    return present ? "R7" : "R8";
  endfunction

  // pin-level PHY model and bus monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mdio_o !== prev_o && mdc) r5_bad++;
      prev_o = mdio_o;
      if (mdc !== prev_mdc) begin
        if (have_tog && seg != H) half_bad++;
        have_tog = 1'b1;
        seg = 1;
      end else begin
        seg++;
      end
      if (mdc && !prev_mdc) begin
        if (nrise < 128) begin
          obs_o[nrise]  = mdio_o;
          obs_oe[nrise] = mdio_oe;
        end
        if (!phy_present || !rd_frame) mdio_i = 1'b1;
        else if (nrise == 48) mdio_i = 1'b0;
        else if (nrise >= 49 && nrise <= 64) mdio_i = phy_data[64-nrise];
        else mdio_i = 1'b1;
        nrise++;
      end
      prev_mdc = mdc;
      if (done) done_cnt++;
    end
  end

  task automatic frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input bit present,
                       input logic [15:0] pdata, input bit inject,
                       input logic [15:0] prev_rdata);
    int cyc;
    int exp_n;
    logic [1:0] e;
    @(negedge clk);
    nrise = 0; done_cnt = 0; half_bad = 0; r5_bad = 0; have_tog = 1'b0;
    rd_frame = rd; phy_present = present; phy_data = pdata;
    rd_wr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 40) begin
        rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
      end
      if (inject && cyc == 41) start = 1'b0;
      if (!done && rdata !== prev_rdata)
        chk(1'b0, "R11", "rdata moved before done", rdata, prev_rdata);
    end
    chk(done == 1'b1, "R9", "frame completed", done, 1);
    chk(busy == 1'b1, "R9", "busy during done", busy, 1);
    exp_n = rd ? (present ? 67 : 81) : 66;
    if (rd) begin
      chk(rdata == (present ? pdata : 16'hFFFF), present ? "R7" : "R8",
          "rdata", rdata, present ? pdata : 16'hFFFF);
    end else begin
      chk(rdata == prev_rdata, "R11", "rdata kept by write", rdata, prev_rdata);
    end
    chk(nophy == (rd && !present), rd ? (present ? "R7" : "R8") : "R11",
        "nophy", nophy, (rd && !present));
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after done", busy, 0);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk(mdc == 1'b0, "R1", "mdc idle low", mdc, 0);
    chk(done_cnt == 1, inject ? "R10" : "R9", "done count", done_cnt, 1);
    chk(half_bad == 0, "R1", "half period mismatches", half_bad, 0);
    chk(r5_bad == 0, "R5", "mdio changed with mdc high", r5_bad, 0);
    chk(nrise == exp_n, rd ? (present ? "R7" : "R8") : "R6", "mdc cycles", nrise, exp_n);
    for (int s = 0; s < exp_n && s < 128; s++) begin
      e = exp_slot(s, rd, pa, ra, wd);
      chk({obs_oe[s], obs_o[s]} == e, inject ? "R10" : slot_req(s, rd, present),
          $sformatf("slot %0d oe/o", s), {obs_oe[s], obs_o[s]}, e);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] last_rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc == 1'b0, "R1", "reset mdc", mdc, 0);
    chk(mdio_oe == 1'b0, "R1", "reset oe", mdio_oe, 0);
    chk(busy == 1'b0, "R9", "reset busy", busy, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(nophy == 1'b0, "R11", "reset nophy", nophy, 0);
    last_rd = 16'h0000;
    // writes across every PHY address
    for (int p = 0; p < 32; p++) begin
      frame(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0841) ^ 16'hA5C3,
            1'b1, 16'h0, 1'b0, last_rd);
    end
    // reads across every register address with a present PHY
    for (int r = 0; r < 32; r++) begin
      logic [15:0] pd;
      pd = {5'(r), ~5'(r), 6'(r * 3)};
      frame(1'b1, 5'(r ^ 5'h15), 5'(r), 16'h0, 1'b1, pd, 1'b0, last_rd);
      last_rd = pd;
    end
    // R8: absent PHY
    for (int k = 0; k < 4; k++) begin
      frame(1'b1, 5'(k * 7), 5'(k + 2), 16'h0, 1'b0, 16'h1234, 1'b0, last_rd);
      last_rd = 16'hFFFF;
    end
    // R11: write after a failed read keeps rdata and clears nophy
    frame(1'b0, 5'h03, 5'h1C, 16'h8001, 1'b1, 16'h0, 1'b0, last_rd);
    // R7: recovered PHY answers again
    frame(1'b1, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h0000, 1'b0, last_rd);
    last_rd = 16'h0000;
    frame(1'b1, 5'h00, 5'h1F, 16'h0, 1'b1, 16'hFFFF, 1'b0, last_rd);
    last_rd = 16'hFFFF;
    // R10: start during a frame is ignored
    frame(1'b0, 5'h0A, 5'h15, 16'h5A5A, 1'b1, 16'h0, 1'b1, last_rd);
    frame(1'b1, 5'h11, 5'h0E, 16'h0, 1'b1, 16'hC3A5, 1'b1, last_rd);
    last_rd = 16'hC3A5;
    // R11: results hold while idle
    repeat (50) @(negedge clk);
    chk(rdata == last_rd, "R11", "rdata held idle", rdata, last_rd);
    chk(nophy == 1'b0, "R11", "nophy held idle", nophy, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule